// File: doc/BRIEF.md
# Bulk register transfer packet framer

This block frames and checks packets that move register contents in bulk over an audio-style data port of a serial audio bus. Its transmit side takes a 7-byte header descriptor, a payload length and an active flag. It emits a byte stream over a valid/ready handshake in this order: the header, a one-byte header CRC, the payload, a one-byte payload CRC and a footer-response slot. Framing overhead is therefore ten bytes per packet. An idle (inactive) packet keeps the stream moving without touching any payload source.

The receive side watches a byte stream that carries the same framing. It recomputes both CRCs and raises a one-cycle error pulse when a received CRC byte disagrees. It also hands the footer byte back unchanged. A small combinational helper turns a row width N into the data-port timing values that such packets use.

Both CRCs are CRC-8 with polynomial 0x07, processed MSB first, with an initial value of 0x00. The header CRC covers only the seven header bytes. The payload CRC covers only the payload bytes.

Top module: `brx_framer`

## Requirements
- R1: After a start request is accepted, the first seven output bytes are the header, taken from `tx_hdr` most significant byte first (`tx_hdr[55:48]` first). `tx_out_sop` is high only on the first of these bytes.
- R2: The eighth output byte is the CRC-8 (poly 0x07, init 0x00, MSB first) of the seven header bytes.
- R3: In an active packet, the next `tx_len` output bytes are the payload bytes, taken in order from the payload input stream (one per `tx_pl_valid`/`tx_pl_ready` handshake).
- R4: The second-to-last byte is the CRC-8 of the payload bytes alone (0x00 when `tx_len` is 0). The last byte is a 0x00 footer slot and carries `tx_out_last`.
- R5: Every packet is exactly `tx_len` + 10 bytes long.
- R6: For an inactive packet (`tx_active` = 0 at the start), `tx_pl_ready` stays low, every payload byte is 0x00, and `tx_out_active` is low. For an active packet, `tx_out_active` is high.
- R7: While `tx_out_valid` is high and `tx_out_ready` is low, the output byte and the packet position hold, so the CRCs are not disturbed.
- R8: A start request is taken only while `tx_idle` is high. A request made during a packet does not change that packet, and `tx_idle` returns high in the cycle after the footer handshake.
- R9: `rx_hdr_err` pulses for exactly one cycle, in the cycle after the received header-CRC byte, when that byte differs from the CRC of the seven received header bytes. Otherwise it stays low.
- R10: `rx_data_err` pulses for one cycle after the payload-CRC byte when that byte mismatches, and only for packets started with `rx_active` high.
- R11: The received footer byte appears on `rx_foot_data`, with a one-cycle `rx_foot_valid`, in the cycle after it is accepted.
- R12: For row width N on `row_w`, the outputs are: `cfg_hstart` = 1, `cfg_hstop` = N-1, `cfg_interval` = N, and `cfg_wordlen` = N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Start request for a new packet |
| tx_hdr | input | 56 | Header bytes, MSB byte sent first |
| tx_len | input | LEN_W | Payload byte count |
| tx_active | input | 1 | Packet carries valid data |
| tx_idle | output | 1 | No packet in progress, start may be taken |
| tx_pl_data | input | 8 | Payload byte |
| tx_pl_valid | input | 1 | Payload byte available |
| tx_pl_ready | output | 1 | Payload byte consumed this cycle |
| tx_out_data | output | 8 | Framed output byte |
| tx_out_valid | output | 1 | Output byte valid |
| tx_out_ready | input | 1 | Downstream accepts byte |
| tx_out_sop | output | 1 | First header byte |
| tx_out_last | output | 1 | Footer slot byte |
| tx_out_active | output | 1 | Active flag of current packet |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sop | input | 1 | Received byte is the first header byte |
| rx_len | input | LEN_W | Payload length of received packet |
| rx_active | input | 1 | Received packet is active |
| rx_hdr_err | output | 1 | Header CRC mismatch pulse |
| rx_data_err | output | 1 | Payload CRC mismatch pulse |
| rx_foot_valid | output | 1 | Footer byte pulse |
| rx_foot_data | output | 8 | Footer byte |
| row_w | input | RW_W | Row width N |
| cfg_hstart | output | RW_W | Start column |
| cfg_hstop | output | RW_W | Stop column |
| cfg_interval | output | RW_W | Sampling interval |
| cfg_wordlen | output | RW_W | Word length |

## Verification
The hold check on a stalled output assumes that the payload source keeps `tx_pl_valid` and its byte steady until the byte is taken. The bench changes the payload byte only after a handshake and only ever drops `tx_pl_valid` between bytes. The receive checks assume that `rx_sop` marks the first header byte and that `rx_len`/`rx_active` are valid in that same cycle. The bench builds every received packet to satisfy this, and it inserts idle gaps only between bytes. Row widths are swept from 2 upward, so N-1 never underflows.

// File: rtl/brx_pkg.sv
package brx_pkg;
    localparam int HDR_BYTES = 7;
    localparam int HDR_W     = HDR_BYTES * 8;
    localparam int OVERHEAD  = HDR_BYTES + 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_HCRC, ST_PAY, ST_DCRC, ST_FOOT
    } frm_state_e;

    typedef struct packed {
        logic [HDR_W-1:0] hdr;
        logic             active;
    } tx_desc_t;

    function automatic logic [7:0] crc8_next(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction
endpackage

// File: rtl/brx_crc8_acc.sv
module brx_crc8_acc
    import brx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)            crc <= 8'h00;
        else if (clr && en) crc <= crc8_next(8'h00, din);
        else if (clr)       crc <= 8'h00;
        else if (en)        crc <= crc8_next(crc, din);
    end
endmodule

// File: rtl/brx_tx.sv
module brx_tx
    import brx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  tx_desc_t         desc_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             idle_o,
    input  logic [7:0]       pl_data_i,
    input  logic             pl_valid_i,
    output logic             pl_ready_o,
    output logic [7:0]       out_data_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             out_sop_o,
    output logic             out_last_o,
    output logic             out_active_o
);
    localparam int TOT_W = LEN_W + 5;

    frm_state_e       state;
    logic [HDR_W-1:0] hdr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] bcnt;
    logic             act_q;
    logic [TOT_W-1:0] tot;
    logic [7:0]       hcrc, dcrc;
    logic             accept, xfer;

    assign accept = (state == ST_IDLE) && start_i;
    assign xfer   = out_valid_o && out_ready_i;
    assign idle_o = (state == ST_IDLE);

    brx_crc8_acc u_hcrc (.clk(clk), .rst(rst), .clr(accept),
                         .en(xfer && state == ST_HDR), .din(out_data_o), .crc(hcrc));
    brx_crc8_acc u_dcrc (.clk(clk), .rst(rst), .clr(accept),
                         .en(xfer && state == ST_PAY), .din(out_data_o), .crc(dcrc));

    always_comb begin
        out_data_o  = 8'h00;
        out_valid_o = 1'b0;
        pl_ready_o  = 1'b0;
        unique case (state)
            ST_HDR:  begin out_valid_o = 1'b1; out_data_o = hdr_q[HDR_W-1 -: 8]; end
            ST_HCRC: begin out_valid_o = 1'b1; out_data_o = hcrc; end
            ST_PAY: begin
                out_valid_o = act_q ? pl_valid_i : 1'b1;
                out_data_o  = act_q ? pl_data_i : 8'h00;
                pl_ready_o  = act_q && pl_valid_i && out_ready_i;
            end
            ST_DCRC: begin out_valid_o = 1'b1; out_data_o = dcrc; end
            ST_FOOT: out_valid_o = 1'b1;
            default: ;
        endcase
    end

    assign out_sop_o    = (state == ST_HDR) && (bcnt == '0);
    assign out_last_o   = (state == ST_FOOT);
    assign out_active_o = (state != ST_IDLE) && act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            hdr_q <= '0;
            len_q <= '0;
            bcnt  <= '0;
            act_q <= 1'b0;
            tot   <= '0;
        end else if (accept) begin
            state <= ST_HDR;
            hdr_q <= desc_i.hdr;
            act_q <= desc_i.active;
            len_q <= len_i;
            bcnt  <= '0;
            tot   <= '0;
        end else if (xfer) begin
            tot <= tot + 1'b1;
            unique case (state)
                ST_HDR: begin
                    hdr_q <= hdr_q << 8;
                    if (bcnt == LEN_W'(HDR_BYTES - 1)) begin
                        bcnt  <= '0;
                        state <= ST_HCRC;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_HCRC: state <= (len_q == '0) ? ST_DCRC : ST_PAY;
                ST_PAY: begin
                    if (bcnt == len_q - 1'b1) begin
                        bcnt  <= '0;
                        state <= ST_DCRC;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_DCRC: state <= ST_FOOT;
                ST_FOOT: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: packet length
    p_len_total_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer && out_last_o) |-> (TOT_W'(tot + 1'b1) == TOT_W'(len_q) + TOT_W'(OVERHEAD)));
    // R6: inactive packets never pull payload
    p_idle_pkt_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_active_o) |-> !pl_ready_o);
    // R7: stall holds position
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> ($stable(state) && $stable(bcnt)));
    // R8: back to idle after footer
    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer && out_last_o) |=> idle_o);
endmodule

// File: rtl/brx_rx.sv
module brx_rx
    import brx_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [7:0]       data_i,
    input  logic             sop_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             active_i,
    output logic             hdr_err_o,
    output logic             data_err_o,
    output logic             foot_valid_o,
    output logic [7:0]       foot_data_o
);
    frm_state_e       state;
    logic [LEN_W-1:0] len_q, bcnt;
    logic             act_q;
    logic [7:0]       hcrc, dcrc;
    logic             start, hen, den, dclr;

    assign start = valid_i && sop_i;
    assign hen   = valid_i && (sop_i || state == ST_HDR);
    assign den   = valid_i && !sop_i && state == ST_PAY;
    assign dclr  = start;

    brx_crc8_acc u_hcrc (.clk(clk), .rst(rst), .clr(start), .en(hen),
                         .din(data_i), .crc(hcrc));
    brx_crc8_acc u_dcrc (.clk(clk), .rst(rst), .clr(dclr), .en(den),
                         .din(data_i), .crc(dcrc));

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            len_q        <= '0;
            bcnt         <= '0;
            act_q        <= 1'b0;
            hdr_err_o    <= 1'b0;
            data_err_o   <= 1'b0;
            foot_valid_o <= 1'b0;
            foot_data_o  <= 8'h00;
        end else begin
            hdr_err_o    <= 1'b0;
            data_err_o   <= 1'b0;
            foot_valid_o <= 1'b0;
            if (start) begin
                state <= ST_HDR;
                len_q <= len_i;
                act_q <= active_i;
                bcnt  <= LEN_W'(1);
            end else if (valid_i) begin
                unique case (state)
                    ST_HDR: begin
                        if (bcnt == LEN_W'(HDR_BYTES - 1)) begin
                            bcnt  <= '0;
                            state <= ST_HCRC;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_HCRC: begin
                        hdr_err_o <= (data_i != hcrc);
                        state     <= (len_q == '0) ? ST_DCRC : ST_PAY;
                    end
                    ST_PAY: begin
                        if (bcnt == len_q - 1'b1) begin
                            bcnt  <= '0;
                            state <= ST_DCRC;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    ST_DCRC: begin
                        data_err_o <= act_q && (data_i != dcrc);
                        state      <= ST_FOOT;
                    end
                    ST_FOOT: begin
                        foot_valid_o <= 1'b1;
                        foot_data_o  <= data_i;
                        state        <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: header error is a single-cycle pulse
    p_hdr_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        hdr_err_o |=> !hdr_err_o);
    // R10: payload error single-cycle and only for active packets
    p_data_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        data_err_o |=> !data_err_o);
    p_data_active_r10: assert property (@(posedge clk) disable iff (rst)
        data_err_o |-> act_q);
    // R11: footer strobe single cycle
    p_foot_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        foot_valid_o |=> !foot_valid_o);
endmodule

// File: rtl/brx_rowcfg.sv
module brx_rowcfg #(
    parameter int RW_W = 8
) (
    input  logic [RW_W-1:0] row_w_i,
    output logic [RW_W-1:0] hstart_o,
    output logic [RW_W-1:0] hstop_o,
    output logic [RW_W-1:0] interval_o,
    output logic [RW_W-1:0] wordlen_o
);
    assign hstart_o   = RW_W'(1);
    assign hstop_o    = row_w_i - 1'b1;
    assign interval_o = row_w_i;
    assign wordlen_o  = row_w_i - 1'b1;

    // R12: data window sits inside the row
    always_comb begin
        if (row_w_i >= RW_W'(2))
            p_window_r12: assert (hstart_o <= hstop_o && hstop_o < interval_o);
    end
endmodule

// File: rtl/brx_framer.sv
module brx_framer
    import brx_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int RW_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_start,
    input  logic [55:0]      tx_hdr,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_active,
    output logic             tx_idle,
    input  logic [7:0]       tx_pl_data,
    input  logic             tx_pl_valid,
    output logic             tx_pl_ready,
    output logic [7:0]       tx_out_data,
    output logic             tx_out_valid,
    input  logic             tx_out_ready,
    output logic             tx_out_sop,
    output logic             tx_out_last,
    output logic             tx_out_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_sop,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_active,
    output logic             rx_hdr_err,
    output logic             rx_data_err,
    output logic             rx_foot_valid,
    output logic [7:0]       rx_foot_data,
    input  logic [RW_W-1:0]  row_w,
    output logic [RW_W-1:0]  cfg_hstart,
    output logic [RW_W-1:0]  cfg_hstop,
    output logic [RW_W-1:0]  cfg_interval,
    output logic [RW_W-1:0]  cfg_wordlen
);
    tx_desc_t desc;
    assign desc.hdr    = tx_hdr;
    assign desc.active = tx_active;

    brx_tx #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .start_i(tx_start), .desc_i(desc), .len_i(tx_len),
        .idle_o(tx_idle), .pl_data_i(tx_pl_data), .pl_valid_i(tx_pl_valid),
        .pl_ready_o(tx_pl_ready), .out_data_o(tx_out_data), .out_valid_o(tx_out_valid),
        .out_ready_i(tx_out_ready), .out_sop_o(tx_out_sop), .out_last_o(tx_out_last),
        .out_active_o(tx_out_active));

    brx_rx #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst), .valid_i(rx_valid), .data_i(rx_data), .sop_i(rx_sop),
        .len_i(rx_len), .active_i(rx_active), .hdr_err_o(rx_hdr_err),
        .data_err_o(rx_data_err), .foot_valid_o(rx_foot_valid), .foot_data_o(rx_foot_data));

    brx_rowcfg #(.RW_W(RW_W)) u_cfg (
        .row_w_i(row_w), .hstart_o(cfg_hstart), .hstop_o(cfg_hstop),
        .interval_o(cfg_interval), .wordlen_o(cfg_wordlen));
endmodule

// File: tb/sim_brx_framer.sv
module sim_brx_framer;
    localparam int CLK_P = 10;
    localparam int LEN_W = 8;
    localparam int RW_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_start = 0, tx_active = 0, tx_pl_valid = 0, tx_out_ready = 0;
    logic [55:0] tx_hdr = '0;
    logic [LEN_W-1:0] tx_len = '0;
    logic [7:0] tx_pl_data = '0;
    logic tx_idle, tx_pl_ready, tx_out_valid, tx_out_sop, tx_out_last, tx_out_active;
    logic [7:0] tx_out_data;
    logic rx_valid = 0, rx_sop = 0, rx_active = 0;
    logic [7:0] rx_data = '0;
    logic [LEN_W-1:0] rx_len = '0;
    logic rx_hdr_err, rx_data_err, rx_foot_valid;
    logic [7:0] rx_foot_data;
    logic [RW_W-1:0] row_w = 8'd8;
    logic [RW_W-1:0] cfg_hstart, cfg_hstop, cfg_interval, cfg_wordlen;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    brx_framer #(.LEN_W(LEN_W), .RW_W(RW_W)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int k = 0; k < 8; k++)
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    function automatic logic [7:0] pay(input int sd, input int i);
        return 8'((sd * 37) + (i * 13) + 5);
    endfunction

    task automatic run_tx(input logic [55:0] h, input int len, input logic act,
                          input int stall, input int sd);
        logic [7:0] exp [0:299];
        int n = len + 10, got = 0, pidx = 0, cyc = 0;
        int e_hdr = 0, e_hc = 0, e_pay = 0, e_dc = 0, e_ft = 0, e_sop = 0, e_last = 0,
            e_act = 0, e_hold = 0;
        logic [7:0] c = 8'h00, prevb = 8'h00;
        bit prevst = 0;
        for (int k = 0; k < 7; k++) begin
            exp[k] = h[55 - 8*k -: 8];
            c = ref_crc(c, exp[k]);
        end
        exp[7] = c;
        c = 8'h00;
        for (int i = 0; i < len; i++) begin
            exp[8+i] = act ? pay(sd, i) : 8'h00;
            c = ref_crc(c, exp[8+i]);
        end
        exp[8+len] = c;
        exp[9+len] = 8'h00;
        @(negedge clk);
        check(tx_idle == 1'b1, "R8 idle before start", int'(tx_idle), 1);
        tx_start = 1; tx_hdr = h; tx_len = LEN_W'(len); tx_active = act;
        @(negedge clk);
        tx_start = 0;
        while (got < n && cyc < 5000) begin
            if (cyc != 0) @(negedge clk);
            tx_out_ready = (stall == 0) || (cyc % stall != 0);
            tx_pl_valid  = (stall == 0) || (cyc % (stall + 1) != 1);
            tx_pl_data   = pay(sd, pidx);
            // R8: start request mid-packet with a different header
            tx_start = (cyc == 3);
            tx_hdr   = (cyc == 3) ? ~h : h;
            #1;
            if (prevst && tx_out_valid && tx_out_data != prevb) e_hold++;
            prevst = tx_out_valid && !tx_out_ready;
            prevb  = tx_out_data;
            if (tx_pl_valid && tx_pl_ready) pidx++;
            if (tx_out_valid && tx_out_ready) begin
                if (got < 7 && tx_out_data != exp[got]) e_hdr++;
                if (got == 7 && tx_out_data != exp[got]) e_hc++;
                if (got >= 8 && got < 8 + len && tx_out_data != exp[got]) e_pay++;
                if (got == 8 + len && tx_out_data != exp[got]) e_dc++;
                if (got == 9 + len && tx_out_data != exp[got]) e_ft++;
                if (tx_out_sop != (got == 0)) e_sop++;
                if (tx_out_last != (got == n - 1)) e_last++;
                if (tx_out_active != act) e_act++;
                got++;
            end
            cyc++;
        end
        tx_start = 0;
        check(e_hdr == 0, "R1 header bytes", e_hdr, 0);
        check(e_sop == 0, "R1 sop marker", e_sop, 0);
        check(e_hc == 0, "R2 header crc", e_hc, 0);
        check(e_pay == 0, act ? "R3 payload bytes" : "R6 zero payload", e_pay, 0);
        check(e_dc == 0 && e_ft == 0 && e_last == 0, "R4 crc/footer/last", e_dc + e_ft + e_last, 0);
        check(got == n, "R5 packet length", got, n);
        check(e_act == 0, "R6 active flag", e_act, 0);
        check(pidx == (act ? len : 0), act ? "R3 payload consumed" : "R6 no payload consumed",
              pidx, act ? len : 0);
        check(e_hold == 0, "R7 stall hold", e_hold, 0);
        @(negedge clk);
        #1;
        check(tx_idle == 1'b1 && tx_out_valid == 1'b0, "R8 idle after footer", int'(tx_idle), 1);
    endtask

    // corrupt: 0 none, 1 header byte, 2 payload (or payload crc), 3 header crc byte
    task automatic run_rx(input logic [55:0] h, input int len, input logic act,
                          input int corrupt, input int gap);
        logic [7:0] b [0:299];
        int n = len + 10, nh = 0, nd = 0, nf = 0, hpos = -1, cnt = 0;
        logic [7:0] c = 8'h00, fdat = 8'h00;
        for (int k = 0; k < 7; k++) begin
            b[k] = h[55 - 8*k -: 8];
            c = ref_crc(c, b[k]);
        end
        b[7] = c;
        c = 8'h00;
        for (int i = 0; i < len; i++) begin
            b[8+i] = pay(len, i);
            c = ref_crc(c, b[8+i]);
        end
        b[8+len] = c;
        b[9+len] = 8'h3C ^ 8'(len);
        if (corrupt == 1) b[2] = b[2] ^ 8'h10;
        if (corrupt == 3) b[7] = b[7] ^ 8'h01;
        if (corrupt == 2) begin
            if (len > 0) b[8] = b[8] ^ 8'h80;
            else b[8] = b[8] ^ 8'h04;
        end
        for (int i = 0; i < n; i++) begin
            if (gap != 0 && i % gap == 1) begin
                @(negedge clk);
                rx_valid = 0; rx_sop = 0;
                @(posedge clk); #1;
                cnt++;
                nh += int'(rx_hdr_err); nd += int'(rx_data_err);
                if (rx_foot_valid) begin nf++; fdat = rx_foot_data; end
            end
            @(negedge clk);
            rx_valid = 1; rx_data = b[i]; rx_sop = (i == 0);
            rx_len = LEN_W'(len); rx_active = act;
            @(posedge clk); #1;
            cnt++;
            if (rx_hdr_err && hpos < 0) hpos = i;
            nh += int'(rx_hdr_err); nd += int'(rx_data_err);
            if (rx_foot_valid) begin nf++; fdat = rx_foot_data; end
        end
        @(negedge clk);
        rx_valid = 0; rx_sop = 0;
        for (int w = 0; w < 3; w++) begin
            @(posedge clk); #1;
            nh += int'(rx_hdr_err); nd += int'(rx_data_err);
            if (rx_foot_valid) begin nf++; fdat = rx_foot_data; end
        end
        check(nh == ((corrupt == 1 || corrupt == 3) ? 1 : 0), "R9 header crc pulse", nh,
              (corrupt == 1 || corrupt == 3) ? 1 : 0);
        if (nh == 1 && gap == 0)
            check(hpos == 7, "R9 header pulse timing", hpos, 7);
        check(nd == ((act && corrupt == 2) ? 1 : 0), "R10 payload crc pulse", nd,
              (act && corrupt == 2) ? 1 : 0);
        check(nf == 1 && fdat == (8'h3C ^ 8'(len)), "R11 footer passthrough", int'(fdat),
              int'(8'h3C ^ 8'(len)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check(tx_idle == 1 && tx_out_valid == 0 && tx_pl_ready == 0, "R8 reset idle",
              int'(tx_idle), 1);
        check(rx_hdr_err == 0 && rx_data_err == 0 && rx_foot_valid == 0, "R9 reset quiet",
              int'(rx_hdr_err), 0);

        for (int len = 0; len <= 20; len++)
            for (int a = 0; a < 2; a++)
                for (int st = 0; st < 4; st += 3)
                    run_tx(56'h0102_0304_0506_07 ^ {48'h0, 8'(len)} ^ (56'(a) << 40),
                           len, a[0], st, len + a);
        run_tx(56'hFFFF_FFFF_FFFF_FF, 5, 1'b1, 2, 9);
        run_tx(56'h0, 0, 1'b0, 2, 0);

        for (int len = 0; len <= 12; len++)
            for (int cr = 0; cr < 4; cr++)
                for (int a = 0; a < 2; a++)
                    run_rx(56'hA1B2_C3D4_E5F6_07 + 56'(len * 7 + cr), len, a[0], cr,
                           (len % 3 == 0) ? 0 : 4);

        for (int nw = 2; nw <= 64; nw++) begin
            row_w = RW_W'(nw);
            #1;
            check(cfg_hstart == 1 && cfg_hstop == RW_W'(nw - 1) && cfg_interval == RW_W'(nw)
                  && cfg_wordlen == RW_W'(nw - 1), "R12 port timing", int'(cfg_hstop), nw - 1);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule